// File: doc/BRIEF.md
# Interleaved Vector Load Bank Scheduler

This block turns vector load instructions from two load/store units into single-element accesses to a set of interleaved memory banks. Each unit is given a starting element index, an element count and a small age tag. It then presents one element per cycle, in ascending index order. Each element goes to the bank selected by the low bits of its index. A bank accepts an element only while one of its two ports is free.

A bank is modelled only by how long it is occupied. An access holds its port for a fixed latency, and at the end of that latency the element's completion is reported back to the unit that issued it, together with the element index. The data path is 64 bits per element and is not modelled here. When both units need the last free port of the same bank in the same cycle, the unit whose instruction is older wins. Age is judged on wrapping tags.

Each unit raises a done flag once every element of its vector has completed. The flag stays up until that unit accepts its next instruction.

Top module: `vbank_sched`

## Requirements
- R1: Element index i is served by bank (i mod NBANK), which is the low log2(NBANK) bits of the index. NBANK is a power of two, at least 2, so element 0 of any aligned vector lands in bank 0.
- R2: A start pulse is taken at a clock edge. The unit presents its first element in the next cycle. An element issued in cycle c produces its completion pulse in cycle c+LAT. An unstalled vector of length n started in cycle s therefore completes element k in cycle s+1+k+LAT.
- R3: Each unit issues at most one element per cycle. Completions from a unit arrive in ascending element order, each reporting its own index on that unit's index output.
- R4: Each bank has two ports. Two elements may be issued to the same bank in one cycle if both ports are free. A port is occupied from its issue cycle c through cycle c+LAT-1 and is free again in cycle c+LAT.
- R5: If the bank of a unit's next element has no free port, that unit holds the element and issues nothing until a port of that bank frees.
- R6: When both units want the same bank and exactly one port is free, the older instruction wins. Unit 0 counts as older when (age1 - age0) mod 2^AGEW is below 2^(AGEW-1), which includes equal tags. Otherwise unit 1 is older. With AGEW=3, tag 7 is older than tag 0.
- R7: A start pulse is accepted only while the unit has no element left to issue and none outstanding. A start pulse arriving at any other time is ignored.
- R8: done_o for a unit is low after reset and low while the unit is working. It goes high in the cycle after the last completion pulse of the vector and stays high until the next accepted start.
- R9: After reset every port is free, no completion pulse is produced and both done flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 2 | Per-unit start pulse |
| base_i | input | 2×IDXW | Per-unit first element index |
| len_i | input | 2×LENW | Per-unit element count, 1 or more |
| age_i | input | 2×AGEW | Per-unit instruction age tag |
| cpl_o | output | 2 | Per-unit element completion pulse |
| cpl_idx_o | output | 2×IDXW | Per-unit index of the completing element |
| done_o | output | 2 | Per-unit vector finished flag |

## Verification
The main target is two 40-element loads over 32 banks. In this case element 32 must wait for bank 0, and in one exact cycle both units want its single free port. A design that served the younger instruction, or compared the tags without wrap-around (tag 7 against tag 0), would swap the completion cycles of the two units' later elements. A second case puts two accesses on both ports of bank 0 and then asks for the same bank again. A design with one port per bank, a wrong bank mapping, or a port that frees one cycle early or late would show element 32 completing at the wrong time. A start pulse sent mid-vector must produce no extra completions. The done flag is checked on both sides of the final completion.

// File: rtl/vbank_sched.sv
module vbank_sched #(
  parameter int NBANK = 64,
  parameter int LAT   = 50,
  parameter int IDXW  = 8,
  parameter int LENW  = 8,
  parameter int AGEW  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            start_i,
  input  logic [1:0][IDXW-1:0]  base_i,
  input  logic [1:0][LENW-1:0]  len_i,
  input  logic [1:0][AGEW-1:0]  age_i,
  output logic [1:0]            cpl_o,
  output logic [1:0][IDXW-1:0]  cpl_idx_o,
  output logic [1:0]            done_o
);
  localparam int BW = $clog2(NBANK);
  localparam int TW = $clog2(LAT);
  localparam int OW = $clog2(LAT + 1);
  localparam logic [TW-1:0]   TLOAD = TW'(LAT - 1);
  localparam logic [AGEW-1:0] HALF  = AGEW'(1 << (AGEW - 1));

  logic [1:0][TW-1:0]   tmr [NBANK];
  logic [1:0][IDXW:0]   pipe [LAT];
  logic [1:0][IDXW-1:0] cur;
  logic [1:0][LENW-1:0] rem;
  logic [1:0][AGEW-1:0] age_q;
  logic [1:0][OW-1:0]   outst;
  logic [1:0]           fin, busy, want, gnt;
  logic [1:0][BW-1:0]   bank;
  logic [1:0][1:0]      nfree;
  logic [AGEW-1:0]      adiff;
  logic                 u0_first, same;

  assign adiff    = age_q[1] - age_q[0];
  assign u0_first = adiff < HALF;
  assign same     = bank[0] == bank[1];

  for (genvar u = 0; u < 2; u++) begin : g_unit
    assign bank[u]  = cur[u][BW-1:0];
    assign want[u]  = rem[u] != '0;
    assign busy[u]  = want[u] || (outst[u] != '0);
    assign done_o[u] = fin[u] && !busy[u];
    assign nfree[u] = {1'b0, tmr[bank[u]][0] == '0} + {1'b0, tmr[bank[u]][1] == '0};
    assign cpl_o[u]     = pipe[LAT-1][u][IDXW];
    assign cpl_idx_o[u] = pipe[LAT-1][u][IDXW-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur[u]   <= '0;
        rem[u]   <= '0;
        age_q[u] <= '0;
        outst[u] <= '0;
        fin[u]   <= 1'b0;
      end else begin
        if (start_i[u] && !busy[u]) begin
          cur[u]   <= base_i[u];
          rem[u]   <= len_i[u];
          age_q[u] <= age_i[u];
          fin[u]   <= 1'b1;
        end else if (gnt[u]) begin
          cur[u] <= cur[u] + IDXW'(1);
          rem[u] <= rem[u] - LENW'(1);
        end
        outst[u] <= outst[u] + OW'(gnt[u]) - OW'(cpl_o[u]);
      end
    end

    // R3
    cpl_has_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_o[u] |-> outst[u] != '0);
    // R7
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i[u] && busy[u] |=> $stable(age_q[u]));
    // R5
    stall_holds_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      want[u] && !gnt[u] && !start_i[u] |=> $stable(cur[u]));
    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o[u] |-> !cpl_o[u]);
  end

  always_comb begin
    gnt[0] = want[0] && nfree[0] != 2'd0;
    gnt[1] = want[1] && nfree[1] != 2'd0;
    if (want[0] && want[1] && same && nfree[0] == 2'd1) begin
      gnt[0] = u0_first;
      gnt[1] = !u0_first;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) tmr[b] <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        for (int p = 0; p < 2; p++)
          if (tmr[b][p] != '0) tmr[b][p] <= tmr[b][p] - TW'(1);
        if (gnt[0] && gnt[1] && bank[0] == b[BW-1:0] && same) begin
          tmr[b][0] <= TLOAD;
          tmr[b][1] <= TLOAD;
        end else if ((gnt[0] && bank[0] == b[BW-1:0]) || (gnt[1] && bank[1] == b[BW-1:0])) begin
          if (tmr[b][0] == '0) tmr[b][0] <= TLOAD;
          else                 tmr[b][1] <= TLOAD;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LAT; k++) pipe[k] <= '0;
    end else begin
      for (int u = 0; u < 2; u++) pipe[0][u] <= {gnt[u], cur[u]};
      for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
    end
  end

  // R6
  one_port_one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    want[0] && want[1] && same && nfree[0] == 2'd1 |-> $onehot(gnt));
  // R4
  dual_issue_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[0] && gnt[1] && same |-> nfree[0] == 2'd2);
endmodule

// File: tb/test_vbank_sched.sv
module test_vbank_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 32, LT = 50, IW = 8, LW = 8, AW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] start = '0;
  logic [1:0][IW-1:0] base = '0;
  logic [1:0][LW-1:0] len = '0;
  logic [1:0][AW-1:0] age = '0;
  logic [1:0] cpl, done;
  logic [1:0][IW-1:0] cidx;

  int cyc = 0, checks = 0, fails = 0;
  bit ended = 0;
  int q0i[$], q0c[$], q1i[$], q1c[$];
  string q0r[$], q1r[$];

  vbank_sched #(.NBANK(NB), .LAT(LT), .IDXW(IW), .LENW(LW), .AGEW(AW)) i_vbank_sched (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .len_i(len), .age_i(age),
    .cpl_o(cpl), .cpl_idx_o(cidx), .done_o(done));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int u, int idx, int c, string r);
    if (u == 0) begin q0i.push_back(idx); q0c.push_back(c); q0r.push_back(r); end
    else begin q1i.push_back(idx); q1c.push_back(c); q1r.push_back(r); end
  endtask

  task automatic chk(bit ok, string r, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", r, what, act, exp, cyc);
    end
  endtask

  task automatic mon(int u);
    int ei, ec; string r;
    if ((u == 0 && q0i.size() == 0) || (u == 1 && q1i.size() == 0)) begin
      chk(0, "R3", $sformatf("unexpected completion unit %0d", u), int'(cidx[u]), -1);
      return;
    end
    if (u == 0) begin ei = q0i.pop_front(); ec = q0c.pop_front(); r = q0r.pop_front(); end
    else begin ei = q1i.pop_front(); ec = q1c.pop_front(); r = q1r.pop_front(); end
    chk(int'(cidx[u]) == ei, r, $sformatf("unit %0d index", u), int'(cidx[u]), ei);
    chk(cyc == ec, r, $sformatf("unit %0d element %0d cycle", u, ei), cyc, ec);
  endtask

  always @(negedge clk)
    if (rst_n && !ended)
      for (int u = 0; u < 2; u++) if (cpl[u]) mon(u);

  task automatic go(int u, int b, int l, int a);
    start[u] = 1'b1; base[u] = IW'(b); len[u] = LW'(l); age[u] = AW'(a);
  endtask

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL R2 watchdog expired: actual %0d expected 0", cyc);
    finish_run();
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(cpl == 2'b00, "R9", "completion after reset", int'(cpl), 0);
    chk(done == 2'b00, "R9", "done after reset", int'(done), 0);

    // R2 R3: unstalled 32-element vector, R7: start while busy ignored
    n = cyc;
    go(0, 0, 32, 0);
    for (int k = 0; k < 32; k++) push(0, k, n + 1 + k + LT, "R2 R3");
    @(negedge clk); start = '0;
    wait_cyc(n + 5);
    go(0, 100, 5, 5);
    @(negedge clk); start = '0;
    wait_cyc(n + 82);
    chk(done[0] == 1'b0, "R8", "done before last completion", int'(done[0]), 0);
    chk(done[1] == 1'b0, "R8", "idle unit never started", int'(done[1]), 0);
    @(negedge clk);
    chk(done[0] == 1'b1, "R8", "done after last completion", int'(done[0]), 1);
    chk(q0i.size() == 0, "R7", "pending after ignored start", q0i.size(), 0);
    wait_cyc(n + 90);

    // R5 R6: two 40-element loads over 32 banks, unit 0 older
    n = cyc;
    go(0, 0, 40, 0);
    @(negedge clk); start = '0;
    go(1, 0, 40, 1);
    for (int k = 0; k < 40; k++) begin
      push(0, k, (k < 32) ? n + 1 + k + LT : n + 19 + k + LT, (k < 32) ? "R2" : "R5 R6");
      push(1, k, (k < 32) ? n + 2 + k + LT : n + 20 + k + LT, (k < 32) ? "R4" : "R5 R6");
    end
    @(negedge clk); start = '0;
    wait_cyc(n + 109);
    chk(done[1] == 1'b0, "R8", "unit 1 done early", int'(done[1]), 0);
    @(negedge clk);
    chk(done == 2'b11, "R8", "both done", int'(done), 3);
    wait_cyc(n + 120);

    // R6: same load pair, unit 1 older through tag wrap (7 before 0)
    n = cyc;
    go(1, 0, 40, 7);
    @(negedge clk); start = '0;
    go(0, 0, 40, 0);
    for (int k = 0; k < 40; k++) begin
      push(1, k, (k < 32) ? n + 1 + k + LT : n + 19 + k + LT, "R6");
      push(0, k, (k < 32) ? n + 2 + k + LT : n + 20 + k + LT, "R6");
    end
    @(negedge clk); start = '0;
    wait_cyc(n + 111);
    chk(done == 2'b11, "R8", "both done after wrap case", int'(done), 3);
    wait_cyc(n + 120);

    // R1 R4 R5: both ports of bank 0 taken, element 32 maps back to bank 0
    n = cyc;
    go(0, 0, 33, 0);
    go(1, 32, 1, 1);
    for (int k = 0; k < 32; k++) push(0, k, n + 1 + k + LT, "R1");
    push(0, 32, n + 51 + LT, "R1 R4 R5");
    push(1, 32, n + 1 + LT, "R4");
    @(negedge clk); start = '0;
    wait_cyc(n + 52);
    chk(done[1] == 1'b1, "R8", "single-element done", int'(done[1]), 1);
    wait_cyc(n + 102);
    chk(done[0] == 1'b1, "R8", "stalled vector done", int'(done[0]), 1);

    // R1: offset base wrapping across the bank range, both on bank 30 together
    n = cyc;
    go(1, 30, 4, 2);
    go(0, 62, 2, 3);
    for (int k = 0; k < 4; k++) push(1, 30 + k, n + 1 + k + LT, "R1");
    for (int k = 0; k < 2; k++) push(0, 62 + k, n + 1 + k + LT, "R1 R4");
    @(negedge clk); start = '0;
    wait_cyc(n + 60);

    chk(q0i.size() == 0, "R3", "unit 0 missing completions", q0i.size(), 0);
    chk(q1i.size() == 0, "R3", "unit 1 missing completions", q1i.size(), 0);
    finish_run();
  end
endmodule